// File: doc/BRIEF.md
# Timer Event Capture and Interrupt Unit

This unit sits beside a free-running 64-bit time counter and turns the timing events around it into one interrupt line. Two asynchronous trigger inputs are brought into the clock domain. On a rising edge of either one, the current time is latched into that channel's stamp register. A programmable 64-bit alarm is compared with the running time and raises an event once when the time reaches it. A one-cycle pulse from an external pulse generator is recorded as a further event.

All events land in one sticky status register. Software acknowledges an event by writing a one to its bit. A separate enable mask selects which status bits drive the single interrupt output. Software reads and writes the unit through a simple word-wide register port: the write port is synchronous and the read port is combinational.

Top module: `evt_unit`

## Requirements
- R1: After reset, the status, mask, alarm and stamp registers all read 0 and `irq` is low.
- R2: A rising edge on `trig_in[i]` is captured at the third rising clock edge after the input changes. At that edge the stamp register of channel i loads `time_now`, and status bit i is set.
- R3: A falling edge or a steady level on a trigger input sets no status bit and leaves the stamp registers unchanged.
- R4: The two trigger channels are independent. Channel 0 sets status bit 0 and channel 1 sets status bit 1.
- R5: Writing the alarm high word arms the alarm. While armed, the alarm sets status bit 2 at the first clock edge where `time_now` is greater than or equal to the 64-bit alarm value, and then disarms. It stays disarmed until the high word is written again.
- R6: Writing only the alarm low word does not arm the alarm.
- R7: `pulse_evt` high at a clock edge sets status bit 3.
- R8: Writing to the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: If an event and a clear of the same status bit fall in the same cycle, the bit stays set.
- R10: `irq` is high exactly when some status bit is set whose mask bit is also set. A mask of 0 holds `irq` low.
- R11: Writes to the stamp register addresses have no effect.
- R12: Register addresses are: 0 status, 1 mask, 2 alarm low word, 3 alarm high word, 4 and 5 channel 0 stamp (low, high), 6 and 7 channel 1 stamp (low, high). Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Current time from the counter |
| trig_in | input | 2 | Asynchronous external trigger inputs |
| pulse_evt | input | 1 | One-cycle event from the pulse generator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt, high while any enabled event is pending |

## Verification
Several properties are checked on every cycle:
- A zero mask keeps `irq` low.
- Status bits never drop without a status write.
- A pulse or capture event always leaves its bit set in the next cycle, even when a clear lands on it.
- A stamp changes only in the cycle after its channel's edge is detected.
- A firing alarm disarms unless the high word is rewritten.

Only the bench scenarios can show the rest:
- The exact capture latency and stamp value.
- That falling edges are ignored.
- That a low-word write alone never arms the alarm.
- That an alarm set in the future fires once at the right time.

Every read address is also compared against a reference model on each clock.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int ADDR_EVT        = 0;
    localparam int ADDR_MASK       = 1;
    localparam int ADDR_ALM_LO     = 2;
    localparam int ADDR_ALM_HI     = 3;
    localparam int ADDR_STAMP_BASE = 4;
endpackage

// File: rtl/evt_trig_cap.sv
module evt_trig_cap #(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [TW-1:0] now,
    output logic          hit,
    output logic [TW-1:0] stamp
);
    localparam int SYNC_LEN = 3;

    typedef struct packed {
        logic [SYNC_LEN-1:0] sh;
        logic [TW-1:0]       stamp;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SYNC_LEN-2:0], trig};
        hit     = st_q.sh[1] & ~st_q.sh[2];
        if (hit) begin
            st_d.stamp = now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stamp = st_q.stamp;
endmodule

// File: rtl/evt_alarm.sv
module evt_alarm #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DW-1:0]   wr_data,
    input  logic [2*DW-1:0] now,
    output logic            fire,
    output logic            armed,
    output logic [2*DW-1:0] value
);
    typedef struct packed {
        logic          armed;
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } alm_t;

    alm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = st_q.armed && (now >= {st_q.hi, st_q.lo});
        if (wr_lo) begin
            st_d.lo = wr_data;
        end
        if (wr_hi) begin
            st_d.hi    = wr_data;
            st_d.armed = 1'b1;
        end else if (fire) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;
    assign value = {st_q.hi, st_q.lo};
endmodule

// File: rtl/evt_status.sv
module evt_status #(
    parameter int NEV = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] set,
    input  logic           clr_wr,
    input  logic           mask_wr,
    input  logic [NEV-1:0] wr_bits,
    output logic [NEV-1:0] status,
    output logic [NEV-1:0] mask,
    output logic           irq
);
    typedef struct packed {
        logic [NEV-1:0] status;
        logic [NEV-1:0] mask;
    } evs_t;

    evs_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.status = (st_q.status & ~(clr_wr ? wr_bits : '0)) | set;
        if (mask_wr) begin
            st_d.mask = wr_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.status;
    assign mask   = st_q.mask;
    assign irq    = |(st_q.status & st_q.mask);
endmodule

// File: rtl/evt_unit.sv
module evt_unit #(
    parameter int N_TRIG = 2,
    parameter int DW     = 32,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*DW-1:0]   time_now,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic              pulse_evt,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              irq
);
    import evt_pkg::*;

    localparam int TW  = 2 * DW;
    localparam int NEV = N_TRIG + 2;

    logic                         wr_evt, wr_mask, wr_alo, wr_ahi;
    logic [N_TRIG-1:0]            cap_hit;
    logic [N_TRIG-1:0][TW-1:0]    cap_stamp;
    logic                         alm_fire, alm_armed;
    logic [TW-1:0]                alm_value;
    logic [NEV-1:0]               ev_status, ev_mask;

    assign wr_evt  = wr_en && (wr_addr == AW'(ADDR_EVT));
    assign wr_mask = wr_en && (wr_addr == AW'(ADDR_MASK));
    assign wr_alo  = wr_en && (wr_addr == AW'(ADDR_ALM_LO));
    assign wr_ahi  = wr_en && (wr_addr == AW'(ADDR_ALM_HI));

    for (genvar g = 0; g < N_TRIG; g++) begin : g_cap
        evt_trig_cap #(.TW(TW)) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .trig  (trig_in[g]),
            .now   (time_now),
            .hit   (cap_hit[g]),
            .stamp (cap_stamp[g])
        );
    end

    evt_alarm #(.DW(DW)) u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_alo),
        .wr_hi   (wr_ahi),
        .wr_data (wr_data),
        .now     (time_now),
        .fire    (alm_fire),
        .armed   (alm_armed),
        .value   (alm_value)
    );

    evt_status #(.NEV(NEV)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     ({pulse_evt, alm_fire, cap_hit}),
        .clr_wr  (wr_evt),
        .mask_wr (wr_mask),
        .wr_bits (wr_data[NEV-1:0]),
        .status  (ev_status),
        .mask    (ev_mask),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADDR_EVT)) begin
            rd_data = DW'(ev_status);
        end
        if (rd_addr == AW'(ADDR_MASK)) begin
            rd_data = DW'(ev_mask);
        end
        if (rd_addr == AW'(ADDR_ALM_LO)) begin
            rd_data = alm_value[DW-1:0];
        end
        if (rd_addr == AW'(ADDR_ALM_HI)) begin
            rd_data = alm_value[TW-1:DW];
        end
        for (int i = 0; i < N_TRIG; i++) begin
            if (rd_addr == AW'(ADDR_STAMP_BASE + 2 * i)) begin
                rd_data = cap_stamp[i][DW-1:0];
            end
            if (rd_addr == AW'(ADDR_STAMP_BASE + 2 * i + 1)) begin
                rd_data = cap_stamp[i][TW-1:DW];
            end
        end
    end
endmodule

// File: rtl/evt_unit_chk.sv
module evt_unit_chk #(
    parameter int N_TRIG = 2,
    parameter int DW     = 32,
    parameter int AW     = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [AW-1:0]                   wr_addr,
    input logic                            pulse_evt,
    input logic                            irq,
    input logic [N_TRIG+1:0]               status,
    input logic [N_TRIG+1:0]               mask,
    input logic                            alarm_fire,
    input logic                            alarm_armed,
    input logic [N_TRIG-1:0]               cap_hit,
    input logic [N_TRIG-1:0][2*DW-1:0]     stamps
);
    import evt_pkg::*;

    localparam int NEV = N_TRIG + 2;

    p_mask_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == AW'(ADDR_EVT)) |=> ((status & $past(status)) == $past(status)));

    // R7 also: a pulse always leaves its bit set
    p_pulse_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_evt |=> status[NEV-1]);

    p_alarm_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_fire && !(wr_en && wr_addr == AW'(ADDR_ALM_HI))) |=> !alarm_armed);

    for (genvar g = 0; g < N_TRIG; g++) begin : g_ch
        p_hit_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cap_hit[g] |=> status[g]);
        p_stamp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_hit[g] |=> $stable(stamps[g]));
    end
endmodule

bind evt_unit evt_unit_chk #(.N_TRIG(N_TRIG), .DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .pulse_evt   (pulse_evt),
    .irq         (irq),
    .status      (ev_status),
    .mask        (ev_mask),
    .alarm_fire  (alm_fire),
    .alarm_armed (alm_armed),
    .cap_hit     (cap_hit),
    .stamps      (cap_stamp)
);

// File: tb/evt_unit_bench.sv
module evt_unit_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tcnt = 64'h0000_0001_FFFF_FFF0;
    logic [1:0]  trig = '0;
    logic        pulse_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int rot = 0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) tcnt <= tcnt + 64'd1;

    evt_unit u_evt_unit (
        .clk(clk), .rst_n(rst_n), .time_now(tcnt), .trig_in(trig),
        .pulse_evt(pulse_evt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // behavioural reference model
    logic [1:0]  m_hist[$];
    logic [63:0] m_stamp[2];
    logic [63:0] m_alarm;
    logic        m_armed;
    logic [3:0]  m_status, m_mask;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist   = '{2'b00, 2'b00, 2'b00};
            m_stamp[0] = '0;
            m_stamp[1] = '0;
            m_alarm  = '0;
            m_armed  = 1'b0;
            m_status = '0;
            m_mask   = '0;
        end else begin
            logic [3:0] ev;
            logic [3:0] clr;
            logic       fire;
            ev = '0;
            for (int c = 0; c < 2; c++) begin
                if (m_hist[1][c] && !m_hist[2][c]) begin
                    ev[c] = 1'b1;
                    m_stamp[c] = tcnt;
                end
            end
            fire  = m_armed && (tcnt >= m_alarm);
            ev[2] = fire;
            ev[3] = pulse_evt;
            clr   = (wr_en && wr_addr == 4'd0) ? wr_data[3:0] : 4'd0;
            m_status = (m_status & ~clr) | ev;
            if (wr_en && wr_addr == 4'd1) m_mask = wr_data[3:0];
            if (wr_en && wr_addr == 4'd2) m_alarm[31:0] = wr_data;
            if (wr_en && wr_addr == 4'd3) begin
                m_alarm[63:32] = wr_data;
                m_armed = 1'b1;
            end else if (fire) begin
                m_armed = 1'b0;
            end
            m_hist.push_front(trig);
            void'(m_hist.pop_back());
        end
    end

    function automatic logic [31:0] exp_rd(logic [3:0] a);
        case (a)
            4'd0: return {28'd0, m_status};
            4'd1: return {28'd0, m_mask};
            4'd2: return m_alarm[31:0];
            4'd3: return m_alarm[63:32];
            4'd4: return m_stamp[0][31:0];
            4'd5: return m_stamp[0][63:32];
            4'd6: return m_stamp[1][31:0];
            4'd7: return m_stamp[1][63:32];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] a);
        case (a)
            4'd0: return "R8";
            4'd1: return "R10";
            4'd2, 4'd3: return "R5";
            4'd4, 4'd5, 4'd6, 4'd7: return "R2";
            default: return "R12";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(tag_of(rd_addr), 64'(rd_data), 64'(exp_rd(rd_addr)));
            check("R10", 64'(irq), 64'(|(m_status & m_mask)));
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk); #1;
            wr_en = 1'b0;
            pulse_evt = 1'b0;
            rd_addr = 4'(rot);
            rot = (rot + 1) % 9;
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d; pulse_evt = 1'b0;
        step(1);
    endtask

    task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
        @(posedge clk); #1;
        wr_en = 1'b0; pulse_evt = 1'b0; rd_addr = a;
        #2;
        check(tag, 64'(rd_data), 64'(exp));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] v0, v1, a;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        rd_chk("R1", 4'd0, 32'd0);
        rd_chk("R1", 4'd1, 32'd0);
        rd_chk("R1", 4'd5, 32'd0);
        check("R1", 64'(irq), 64'd0);
        rd_chk("R12", 4'd9, 32'd0);

        wr(4'd1, 32'hF);
        step(1);
        check("R10", 64'(irq), 64'd0);

        // channel 0 rising edge
        @(posedge clk); #1 trig[0] = 1'b1; v0 = tcnt;
        step(5);
        rd_chk("R2", 4'd0, 32'h1);
        rd_chk("R2", 4'd4, v0[31:0] + 32'd2);
        rd_chk("R2", 4'd5, 32'((v0 + 64'd2) >> 32));
        check("R10", 64'(irq), 64'd1);

        wr(4'd0, 32'h0);
        rd_chk("R8", 4'd0, 32'h1);
        wr(4'd0, 32'h1);
        rd_chk("R8", 4'd0, 32'h0);

        // falling edge is ignored
        @(posedge clk); #1 trig[0] = 1'b0;
        step(6);
        rd_chk("R3", 4'd0, 32'h0);
        rd_chk("R3", 4'd4, v0[31:0] + 32'd2);

        // channel 1
        @(posedge clk); #1 trig[1] = 1'b1; v1 = tcnt;
        step(5);
        rd_chk("R4", 4'd0, 32'h2);
        rd_chk("R4", 4'd6, v1[31:0] + 32'd2);
        rd_chk("R4", 4'd4, v0[31:0] + 32'd2);
        trig[1] = 1'b0;
        wr(4'd0, 32'hF);

        // pulse event
        @(posedge clk); #1 pulse_evt = 1'b1;
        step(2);
        rd_chk("R7", 4'd0, 32'h8);

        // set beats clear in the same cycle
        @(posedge clk); #1 wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h8; pulse_evt = 1'b1;
        step(2);
        rd_chk("R9", 4'd0, 32'h8);

        wr(4'd1, 32'h0);
        step(1);
        check("R10", 64'(irq), 64'd0);
        wr(4'd1, 32'h8);
        step(1);
        check("R10", 64'(irq), 64'd1);
        wr(4'd0, 32'h8);
        rd_chk("R8", 4'd0, 32'h0);

        // stamp registers are read-only
        wr(4'd4, 32'hDEAD_BEEF);
        rd_chk("R11", 4'd4, v0[31:0] + 32'd2);
        wr(4'd7, 32'h1234_5678);
        rd_chk("R11", 4'd7, 32'((v1 + 64'd2) >> 32));

        // low word alone does not arm
        wr(4'd2, 32'h0);
        step(5);
        rd_chk("R6", 4'd0, 32'h0);

        // arm with value in the past: fires once
        wr(4'd3, 32'h0);
        step(2);
        rd_chk("R5", 4'd0, 32'h4);
        wr(4'd0, 32'h4);
        step(10);
        rd_chk("R5", 4'd0, 32'h0);

        // alarm in the future
        a = tcnt + 64'd40;
        wr(4'd2, a[31:0]);
        wr(4'd3, a[63:32]);
        rd_chk("R12", 4'd2, a[31:0]);
        rd_chk("R12", 4'd3, a[63:32]);
        step(10);
        rd_chk("R5", 4'd0, 32'h0);
        step(40);
        rd_chk("R5", 4'd0, 32'h4);
        wr(4'd0, 32'h4);
        step(20);
        rd_chk("R5", 4'd0, 32'h0);

        step(3);
        finish_run();
    end
endmodule